// File: doc/BRIEF.md
# Parallel Flash Command Interface Emulator

This block stands in for the device side of a byte-wide parallel flash part, so that a flash host controller can be exercised against a behavioural target without real storage. The host issues single-byte bus writes and reads. Each write outside an open command is decoded as a command byte. The command chooses what later reads return: array contents, identifier bytes or a status byte. Some commands open a two-write sequence: byte program, block erase, or clearing of the block lock bits.

The array is a small internal memory that comes out of reset filled with 0xFF. Blocks are fixed-size slices of the address space, and each has a lock bit preset by a parameter. Program and erase run for a parameterised number of busy cycles before they change the array. While an operation runs, the ready bit of the status byte stays low. Failed or refused sequences leave sticky error flags in the status byte, and a clear command removes them.

Read data is registered: a read strobe captures the selected byte at the clock edge, and `rdata` holds it until the next read strobe.

Top module: `fci_emulator`

## Requirements
- R1: After reset the block is in array-read mode, every array byte reads 0xFF, no sequence is open, no error flag is set, and a status read returns 0x80.
- R2: Writing 0xFF selects array-read mode; each later read returns the array byte at `addr`. `rdata` changes only at a clock edge where `rd_en` is high.
- R3: Writing 0x90 selects identifier mode. Address `0 << ADDR_SHIFT` returns MFR_CODE, which has odd parity, and address `1 << ADDR_SHIFT` returns DEV_CODE.
- R4: In identifier mode, address `3 << ADDR_SHIFT` returns 0x01 if the master lock is set and 0x00 if not. Any address whose in-block offset equals `2 << ADDR_SHIFT` returns 0x01 if that block is locked and 0x00 if not. All other addresses return 0x00.
- R5: Writing 0x70 selects status mode. The status byte has bit 7 = ready (1 when idle), bit 5 = erase error, bit 4 = program error, bit 1 = lock abort; bits 6, 3, 2 and 0 read 0.
- R6: Writing 0x50 clears bits 5, 4 and 1 of the status byte and leaves the read mode unchanged.
- R7: A write of 0x40 followed by a write of data D to address A replaces the array byte at A with (old AND D) after PROG_CYCLES busy cycles. Ready reads 0 for exactly those cycles, and the block is then in status mode.
- R8: A write of 0x20 followed by a write of 0xD0 to any address in a block sets every byte of that block to 0xFF after ERASE_CYCLES busy cycles. Other blocks are not changed.
- R9: A program or erase aimed at a locked block leaves the array unchanged and starts no busy period. It sets bit 1, plus bit 4 for a program or bit 5 for an erase.
- R10: If a 0x20 or 0x60 write is followed by any byte other than 0xD0, that second write aborts the sequence. It sets bits 5 and 4, selects status mode, and changes neither array nor locks.
- R11: A write of 0x60 followed by a write of 0xD0 clears every block lock bit when the master lock is clear. When the master lock is set, it sets bits 1 and 5 and keeps the locks.
- R12: While a busy period runs, writes are ignored and reads return the status byte.
- R13: A command byte outside the defined set, written when no sequence is open, is ignored and the read mode stays as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe: the byte on `wdata` is taken at the clock edge |
| rd_en | input | 1 | Read strobe: `rdata` is loaded at the clock edge |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Registered read data |

## Verification
The hardest condition to reach is a write that lands while an erase is still busy. It must leave both the read mode and any open sequence untouched, and the only trace it leaves at the ports is that polling keeps returning the status byte. The stimulus issues a 0xFF write on the cycle straight after the erase confirm. It then counts busy polls to within one cycle and checks that the final read is still a status byte, not array data. The refused lock-clear path needs a master lock that the default block never has, so a second instance with that lock set receives the same stimulus and is checked only on that outcome.

// File: rtl/fci_pkg.sv
package fci_pkg;

   typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS} rmode_t;
   typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG, PD_LOCK} pend_t;

   localparam logic [7:0] CMD_ARRAY   = 8'hFF;
   localparam logic [7:0] CMD_IDENT   = 8'h90;
   localparam logic [7:0] CMD_STATUS  = 8'h70;
   localparam logic [7:0] CMD_CLRERR  = 8'h50;
   localparam logic [7:0] CMD_ERASE   = 8'h20;
   localparam logic [7:0] CMD_PROG    = 8'h40;
   localparam logic [7:0] CMD_UNLOCK  = 8'h60;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;

endpackage

// File: rtl/fci_timer.sv
module fci_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             busy,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   // done marks the last busy cycle; the operation lands on that edge
   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= load - 1'b1;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/fci_array.sv
module fci_array #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BLK_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              erase_en,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [7:0] mem_q [DEPTH];

   assign rd_byte = mem_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (erase_en) begin
         for (int i = 0; i < DEPTH; i++)
            if ((ADDR_W'(i) >> BLK_W) == (op_addr >> BLK_W)) mem_q[i] <= 8'hFF;
      end else if (prog_en) begin
         // programming can only pull bits towards zero
         mem_q[op_addr] <= mem_q[op_addr] & op_data;
      end
   end

endmodule

// File: rtl/fci_locks.sv
module fci_locks #(
   parameter int unsigned NBLK      = 4,
   parameter int unsigned LOCK_INIT = 32'h5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_en,
   output logic [NBLK-1:0] locked
);

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      localparam logic INIT = ((LOCK_INIT >> b) & 1) != 0;
      logic lk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        lk_q <= INIT;
         else if (clear_en) lk_q <= 1'b0;
      end
      assign locked[b] = lk_q;
   end

endmodule

// File: rtl/fci_emulator.sv
module fci_emulator
   import fci_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned BLK_W        = 6,
   parameter int unsigned ERASE_CYCLES = 12,
   parameter int unsigned PROG_CYCLES  = 3,
   parameter int unsigned ADDR_SHIFT   = 0,
   parameter int unsigned LOCK_INIT    = 32'h5,
   parameter logic [7:0]  MFR_CODE     = 8'h89,
   parameter logic [7:0]  DEV_CODE     = 8'hAC,
   parameter bit          MASTER_LOCK  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   localparam int unsigned NBLK  = 1 << (ADDR_W - BLK_W);
   localparam int unsigned MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
   localparam int unsigned CNT_W = $clog2(MAXC + 1);
   localparam logic [ADDR_W-1:0] ID_MFR    = '0;
   localparam logic [ADDR_W-1:0] ID_DEV    = ADDR_W'(1) << ADDR_SHIFT;
   localparam logic [ADDR_W-1:0] ID_MASTER = ADDR_W'(3) << ADDR_SHIFT;
   localparam logic [BLK_W-1:0]  LOCK_OFS  = BLK_W'(2) << ADDR_SHIFT;

   // elaboration-time parameter checks
   if (BLK_W < ADDR_SHIFT + 2 || BLK_W >= ADDR_W) begin : g_bad_geom
      $error("fci_emulator: block width must hold the identifier offsets and be below ADDR_W");
   end
   if (NBLK > 32) begin : g_bad_nblk
      $error("fci_emulator: at most 32 blocks supported by LOCK_INIT");
   end
   if (^MFR_CODE == 1'b0) begin : g_bad_parity
      $error("fci_emulator: MFR_CODE must have odd parity");
   end
   if (ERASE_CYCLES == 0 || PROG_CYCLES == 0) begin : g_bad_cycles
      $error("fci_emulator: busy counts must be at least one");
   end

   rmode_t            mode_q;
   pend_t             pend_q;
   logic              st_erase_err, st_prog_err, st_lock_abort;
   logic              busy, done;
   logic              op_erase;
   logic [ADDR_W-1:0] op_addr;
   logic [7:0]        op_data;
   logic [NBLK-1:0]   locked;
   logic [7:0]        arr_byte, id_byte, status_byte, read_byte;
   logic              cmd_go, confirm, wr_locked;
   logic              start_prog, start_erase, lock_clear;
   logic [CNT_W-1:0]  timer_load;

   assign wr_locked   = locked[addr[ADDR_W-1:BLK_W]];
   assign cmd_go      = wr_en && !busy;
   assign confirm     = (wdata == CMD_CONFIRM);
   assign start_prog  = cmd_go && pend_q == PD_PROG && !wr_locked;
   assign start_erase = cmd_go && pend_q == PD_ERASE && confirm && !wr_locked;
   assign lock_clear  = cmd_go && pend_q == PD_LOCK && confirm && !MASTER_LOCK;
   assign timer_load  = start_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);

   fci_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_prog || start_erase),
      .load(timer_load), .busy(busy), .done(done)
   );

   fci_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
      .clk(clk), .rst_n(rst_n), .prog_en(done && !op_erase), .erase_en(done && op_erase),
      .op_addr(op_addr), .op_data(op_data), .rd_addr(addr), .rd_byte(arr_byte)
   );

   fci_locks #(.NBLK(NBLK), .LOCK_INIT(LOCK_INIT)) u_locks (
      .clk(clk), .rst_n(rst_n), .clear_en(lock_clear), .locked(locked)
   );

   // command decoder and status flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q        <= RM_ARRAY;
         pend_q        <= PD_NONE;
         st_erase_err  <= 1'b0;
         st_prog_err   <= 1'b0;
         st_lock_abort <= 1'b0;
         op_erase      <= 1'b0;
         op_addr       <= '0;
         op_data       <= '0;
      end else begin
         if (start_prog || start_erase) begin
            op_erase <= start_erase;
            op_addr  <= addr;
            op_data  <= wdata;
         end
         if (cmd_go) begin
            unique case (pend_q)
               PD_NONE: begin
                  case (wdata)
                     CMD_ARRAY:  mode_q <= RM_ARRAY;
                     CMD_IDENT:  mode_q <= RM_ID;
                     CMD_STATUS: mode_q <= RM_STATUS;
                     CMD_CLRERR: begin
                        st_erase_err  <= 1'b0;
                        st_prog_err   <= 1'b0;
                        st_lock_abort <= 1'b0;
                     end
                     CMD_ERASE:  pend_q <= PD_ERASE;
                     CMD_PROG:   pend_q <= PD_PROG;
                     CMD_UNLOCK: pend_q <= PD_LOCK;
                     default: ;
                  endcase
               end
               PD_PROG: begin
                  pend_q <= PD_NONE;
                  mode_q <= RM_STATUS;
                  if (wr_locked) begin
                     st_lock_abort <= 1'b1;
                     st_prog_err   <= 1'b1;
                  end
               end
               PD_ERASE: begin
                  pend_q <= PD_NONE;
                  mode_q <= RM_STATUS;
                  if (!confirm) begin
                     st_erase_err <= 1'b1;
                     st_prog_err  <= 1'b1;
                  end else if (wr_locked) begin
                     st_lock_abort <= 1'b1;
                     st_erase_err  <= 1'b1;
                  end
               end
               PD_LOCK: begin
                  pend_q <= PD_NONE;
                  mode_q <= RM_STATUS;
                  if (!confirm) begin
                     st_erase_err <= 1'b1;
                     st_prog_err  <= 1'b1;
                  end else if (MASTER_LOCK) begin
                     st_lock_abort <= 1'b1;
                     st_erase_err  <= 1'b1;
                  end
               end
               default: pend_q <= PD_NONE;
            endcase
         end
      end
   end

   assign status_byte = {~busy, 1'b0, st_erase_err, st_prog_err, 2'b00, st_lock_abort, 1'b0};

   always_comb begin
      if (addr == ID_MFR)                      id_byte = MFR_CODE;
      else if (addr == ID_DEV)                 id_byte = DEV_CODE;
      else if (addr == ID_MASTER)              id_byte = {7'b0, MASTER_LOCK};
      else if (addr[BLK_W-1:0] == LOCK_OFS)    id_byte = {7'b0, wr_locked};
      else                                     id_byte = 8'h00;
   end

   always_comb begin
      if (busy || pend_q != PD_NONE || mode_q == RM_STATUS) read_byte = status_byte;
      else if (mode_q == RM_ID)                              read_byte = id_byte;
      else                                                   read_byte = arr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= 8'h00;
      else if (rd_en) rdata <= read_byte;
   end

endmodule

// File: rtl/fci_emulator_chk.sv
module fci_emulator_chk
   import fci_pkg::*;
#(
   parameter int unsigned ERASE_CYCLES = 12,
   parameter int unsigned PROG_CYCLES  = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic       busy,
   input logic       op_erase,
   input logic       st_erase_err,
   input logic       st_prog_err,
   input logic       st_lock_abort,
   input pend_t      pend_q,
   input rmode_t     mode_q
);

   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   // R7, R8: busy lasts exactly the configured count for the operation
   a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == (op_erase ? ERASE_CYCLES : PROG_CYCLES));

   // R12: writes during a busy period leave the decoder state alone
   a_r12_busy_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> $stable(pend_q) && $stable(mode_q));

   // R6: the clear command removes every error flag
   a_r6_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !busy && pend_q == PD_NONE && wdata == CMD_CLRERR
      |=> !st_erase_err && !st_prog_err && !st_lock_abort);

   // R2: read data only moves on a read strobe
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R9: a lock abort never coincides with a started operation
   a_r9_abort_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_lock_abort) |-> !busy);

   // R5, R12: a read taken while busy reports not-ready
   a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && busy |=> !rdata[7]);

endmodule

bind fci_emulator fci_emulator_chk #(
   .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
   .rdata(rdata), .busy(busy), .op_erase(op_erase), .st_erase_err(st_erase_err),
   .st_prog_err(st_prog_err), .st_lock_abort(st_lock_abort),
   .pend_q(pend_q), .mode_q(mode_q)
);

// File: tb/fci_emulator_test.sv
module fci_emulator_test;

   localparam int CLK_PERIOD = 10;
   localparam int EC = 12;
   localparam int PC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata, rdata2;
   logic [7:0] v, v2;
   logic [7:0] model [256];
   int         checks = 0;
   int         errors = 0;
   int         n;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fci_emulator #(.ADDR_W(8), .BLK_W(6), .ERASE_CYCLES(EC), .PROG_CYCLES(PC),
                  .LOCK_INIT(32'h5), .MASTER_LOCK(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   fci_emulator #(.ADDR_W(8), .BLK_W(6), .ERASE_CYCLES(EC), .PROG_CYCLES(PC),
                  .LOCK_INIT(32'h5), .MASTER_LOCK(1'b1)) uut_ml (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata2));

   function automatic logic [7:0] stat(bit rdy, bit e, bit p, bit l);
      return {rdy, 1'b0, e, p, 2'b00, l, 1'b0};
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(logic [7:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      v = rdata; v2 = rdata2;
      rd_en = 1'b0;
   endtask

   task automatic wait_ready();
      n = 0;
      rd(8'h00);
      while (!v[7] && n < 2000) begin
         n++;
         rd(8'h00);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] a, d;
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00); check("R1 array byte 00 after reset", v, 8'hFF);
      rd(8'hC7); check("R1 array byte C7 after reset", v, 8'hFF);
      wr(8'h00, 8'h70); rd(8'h00); check("R1 R5 status after reset", v, stat(1,0,0,0));

      // R2 array mode
      wr(8'h00, 8'hFF); rd(8'h21); check("R2 array read", v, 8'hFF);

      // R3 R4 identifier mode
      wr(8'h00, 8'h90);
      rd(8'h00); check("R3 manufacturer code", v, 8'h89);
      checks++;
      if (^v !== 1'b1) begin errors++; $display("FAIL R3 parity actual=%0b expected=1", ^v); end
      rd(8'h01); check("R3 device code", v, 8'hAC);
      rd(8'h02); check("R4 block0 locked", v, 8'h01);
      rd(8'h42); check("R4 block1 unlocked", v, 8'h00);
      rd(8'h82); check("R4 block2 locked", v, 8'h01);
      rd(8'h03); check("R4 master clear", v, 8'h00);
      check("R4 master set on second instance", v2, 8'h01);
      rd(8'h40); check("R4 other offset", v, 8'h00);

      // R7 program with busy length
      wr(8'h00, 8'h40); wr(8'h45, 8'h3C); model[8'h45] &= 8'h3C;
      wait_ready();
      check("R7 program busy cycles", 8'(n), 8'(PC));
      check("R7 status after program", v, stat(1,0,0,0));
      wr(8'h00, 8'hFF); rd(8'h45); check("R7 programmed byte", v, 8'h3C);
      wr(8'h00, 8'h40); wr(8'h45, 8'hF0); model[8'h45] &= 8'hF0;
      wait_ready();
      wr(8'h00, 8'hFF); rd(8'h45); check("R7 and with old value", v, 8'h30);

      // R9 program locked block
      wr(8'h00, 8'h40); wr(8'h05, 8'h00);
      rd(8'h00); check("R9 program locked status", v, stat(1,0,1,1));
      wr(8'h00, 8'h50); rd(8'h00); check("R6 clear keeps status mode", v, stat(1,0,0,0));
      wr(8'h00, 8'hFF); rd(8'h05); check("R9 locked byte unchanged", v, 8'hFF);
      wr(8'h00, 8'h50); rd(8'h45); check("R6 clear keeps array mode", v, 8'h30);

      // R9 erase locked block
      wr(8'h00, 8'h20); wr(8'h90, 8'hD0);
      rd(8'h00); check("R9 erase locked status", v, stat(1,1,0,1));
      wr(8'h00, 8'h50);

      // R10 bad confirm
      wr(8'h00, 8'h20); wr(8'h60, 8'h33);
      rd(8'h00); check("R10 erase abort status", v, stat(1,1,1,0));
      wr(8'h00, 8'h50); wr(8'h00, 8'hFF);
      rd(8'h45); check("R10 array unchanged", v, 8'h30);
      wr(8'h00, 8'h60); wr(8'h00, 8'h11);
      rd(8'h00); check("R10 unlock abort status", v, stat(1,1,1,0));
      wr(8'h00, 8'h50); wr(8'h00, 8'h90);
      rd(8'h02); check("R10 locks kept", v, 8'h01);

      // R13 unknown command
      wr(8'h00, 8'hFF); wr(8'h00, 8'hAB);
      rd(8'h45); check("R13 unknown command ignored", v, 8'h30);

      // R7 random programs in unlocked blocks 1 and 3
      for (int k = 0; k < 40; k++) begin
         a = {(($urandom % 2) != 0) ? 2'b11 : 2'b01, 6'($urandom)};
         d = 8'($urandom);
         wr(8'h00, 8'h40); wr(a, d); model[a] &= d;
         wait_ready();
      end
      wr(8'h00, 8'hFF);
      for (int k = 0; k < 24; k++) begin
         a = {(($urandom % 2) != 0) ? 2'b11 : 2'b01, 6'($urandom)};
         rd(a); check("R7 random program readback", v, model[a]);
      end

      // R8 erase block 1 with an ignored write during busy (R12)
      wr(8'h00, 8'h20); wr(8'h6A, 8'hD0);
      wr(8'h00, 8'hFF);
      wait_ready();
      check("R8 R12 erase busy polls", 8'(n), 8'(EC - 1));
      check("R12 write during busy ignored", v, stat(1,0,0,0));
      for (int i = 64; i < 128; i++) model[i] = 8'hFF;
      wr(8'h00, 8'hFF);
      for (int i = 64; i < 128; i++) begin
         rd(8'(i)); check("R8 erased byte", v, 8'hFF);
      end
      for (int i = 192; i < 208; i++) begin
         rd(8'(i)); check("R8 other block untouched", v, model[i]);
      end

      // R11 lock clear, refused on the master-locked instance
      wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
      rd(8'h00);
      check("R11 lock clear status", v, stat(1,0,0,0));
      check("R11 master locked refusal", v2, stat(1,1,0,1));
      wr(8'h00, 8'h90);
      rd(8'h02);
      check("R11 block0 now unlocked", v, 8'h00);
      check("R11 master locked keeps lock", v2, 8'h01);
      rd(8'h82); check("R11 block2 now unlocked", v, 8'h00);
      wr(8'h00, 8'h40); wr(8'h05, 8'h5A);
      wait_ready();
      wr(8'h00, 8'hFF); rd(8'h05); check("R11 program after unlock", v, 8'h5A);

      summary();
      $finish;
   end

endmodule